// File: doc/BRIEF.md
# Handshake Pipeline Stage Controller

This block is one stage of a self-timed pipeline, modelled on a system clock. A four-phase request/acknowledge pair faces the upstream sender and a second pair faces the downstream receiver. Two state-holding join cells decide when the stage fires. The first join (capture cell) combines the upstream request with the inverted downstream acknowledge. Its output is the latch enable, which also serves as the upstream acknowledge, and its set event captures the incoming word. The second join (launch cell) combines the latch enable with the inverted downstream acknowledge. Its output is the start strobe for an external combinational function.

A matched-delay unit stands in for the function's completion detector. It is a cycle counter loaded from a configuration input. When it reports completion, the output stage registers the function result onto the downstream data bus and raises the downstream request. When the downstream acknowledge rises, the capture cell and then the launch cell fall. The completion flag and the downstream request then drop, and the stage is ready for the next word once the downstream acknowledge has returned low. A sticky monitor flags handshake misuse on either side.

The state machines are as follows:
- Each join cell has the states C_LOW and C_HIGH. It moves C_LOW→C_HIGH when both inputs are 1 and C_HIGH→C_LOW when both are 0. In every other case it stays where it is.
- The delay unit has the states DLY_IDLE, DLY_RUN and DLY_DONE.
  - DLY_IDLE→DLY_RUN when start is seen and the loaded count is above 1.
  - DLY_IDLE→DLY_DONE when start is seen and the count is 0 or 1.
  - DLY_RUN→DLY_DONE when the count reaches 1.
  - DLY_RUN→DLY_IDLE or DLY_DONE→DLY_IDLE when start is low.
- The output stage has the states OUT_IDLE and OUT_OFFER. It moves OUT_IDLE→OUT_OFFER when start and done are both high, capturing the result at that edge. It moves OUT_OFFER→OUT_IDLE when start is low.
- The monitor has the states MON_OK and MON_ERR. It moves MON_OK→MON_ERR on a violation and has no exit except reset.

Top module: `hs_stage_ctrl`

## Requirements
- R1: After reset, up_ack, latch_en, start, done, dn_req and proto_err are all 0.
- R2: Each join cell goes to 1 when both of its inputs are 1, goes to 0 when both are 0, and otherwise keeps its value.
- R3: With dn_ack low, a high up_req raises latch_en and up_ack at the next clock edge, and fn_arg then equals up_data as sampled at that edge.
- R4: up_ack always equals latch_en.
- R5: start rises one edge after latch_en rises, and only if latch_en was high and dn_ack was low at that edge.
- R6: done rises delay_cfg edges after start rises; a delay_cfg of 0 is treated as 1. delay_cfg must stay stable from the rise of up_req until done.
- R7: dn_req rises one edge after done rises, never earlier, and dn_data then equals fn_res as sampled at that edge.
- R8: dn_data stays unchanged while dn_req is high and dn_ack has not yet risen.
- R9: When dn_ack rises with up_req already low, latch_en and up_ack fall at the next edge. start falls one edge later, and dn_req and done fall one edge after that.
- R10: While dn_ack is high, a high up_req is not accepted: up_ack stays 0 and fn_arg keeps its old value. It is accepted one edge after dn_ack returns low.
- R11: proto_err is set if up_req falls while up_ack is low.
- R12: proto_err is set if dn_ack rises while dn_req is low. proto_err, once set, stays set until reset.
- R13: A run of transfers with varied data, delays and handshake spacing delivers every word in order, as fn_res of that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| delay_cfg | input | CNT_W | Matched delay in cycles (0 acts as 1) |
| up_req | input | 1 | Upstream four-phase request |
| up_ack | output | 1 | Upstream four-phase acknowledge |
| up_data | input | DATA_W | Upstream data word |
| latch_en | output | 1 | Input latch enable |
| fn_arg | output | DATA_W | Latched word fed to the stage function |
| start | output | 1 | Evaluation start strobe |
| fn_res | input | DATA_W | Result of the stage function |
| done | output | 1 | Matched-delay completion |
| dn_req | output | 1 | Downstream four-phase request |
| dn_ack | input | 1 | Downstream four-phase acknowledge |
| dn_data | output | DATA_W | Registered result to the next stage |
| proto_err | output | 1 | Sticky handshake violation flag |

## Verification
An accepted request shows up_ack and fn_arg one edge later. start follows one edge after that, and done follows delay_cfg edges after start. dn_req and dn_data are due one edge after done. After the downstream acknowledge rises, latch_en falls one edge later, start one edge later again, and dn_req and done one edge after that. The bench drives every input on the falling clock edge and samples on the falling edge. It counts falling edges from each stimulus and checks each output exactly at the cycle it is due. It also checks the cycle just before that, so early outputs are caught as well as late ones.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic {
        C_LOW  = 1'b0,
        C_HIGH = 1'b1
    } cel_state_e;

    typedef enum logic [1:0] {
        DLY_IDLE = 2'd0,
        DLY_RUN  = 2'd1,
        DLY_DONE = 2'd2
    } dly_state_e;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_OFFER = 1'b1
    } out_state_e;

    typedef enum logic {
        MON_OK  = 1'b0,
        MON_ERR = 1'b1
    } mon_state_e;

endpackage

// File: rtl/hs_celem.sv
module hs_celem
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic y,
    output logic set_evt
);

    cel_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_LOW:   if (in_a && in_b)   state_d = C_HIGH;
            C_HIGH:  if (!in_a && !in_b) state_d = C_LOW;
            default: state_d = C_LOW;
        endcase
    end

    always_comb begin
        y       = (state_q == C_HIGH);
        set_evt = (state_q == C_LOW) && in_a && in_b;
    end

    // R2: agreeing inputs are copied, differing inputs hold
    p_celem_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a == in_b) |=> (y == $past(in_a)));
    p_celem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a != in_b) |=> $stable(y));

endmodule

// File: rtl/hs_delay_unit.sv
module hs_delay_unit
    import hs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dly_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DLY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DLY_IDLE: begin
                if (start) begin
                    if (cfg <= ONE) begin
                        state_d = DLY_DONE;
                    end else begin
                        state_d = DLY_RUN;
                        cnt_d   = cfg - ONE;
                    end
                end
            end
            DLY_RUN: begin
                if (!start)            state_d = DLY_IDLE;
                else if (cnt_q == ONE) state_d = DLY_DONE;
                else                   cnt_d   = cnt_q - ONE;
            end
            DLY_DONE: begin
                if (!start) state_d = DLY_IDLE;
            end
            default: state_d = DLY_IDLE;
        endcase
    end

    always_comb begin
        done = (state_q == DLY_DONE);
    end

    // R6: completion only ever rises under an active start
    p_done_under_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> start);
    // R9: completion clears one edge after start is seen low
    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

endmodule

// File: rtl/hs_out_stage.sv
module hs_out_stage
    import hs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              done,
    input  logic [DATA_W-1:0] fn_res,
    input  logic              dn_ack,
    output logic              dn_req,
    output logic [DATA_W-1:0] dn_data
);

    out_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) data_q <= fn_res;
        end
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            OUT_IDLE: begin
                if (start && done) begin
                    state_d = OUT_OFFER;
                    take    = 1'b1;
                end
            end
            OUT_OFFER: if (!start) state_d = OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
    end

    always_comb begin
        dn_req  = (state_q == OUT_OFFER);
        dn_data = data_q;
    end

    // R7: downstream request is issued only after completion
    p_req_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req) |-> $past(done));
    // R8: offered data holds until the receiver acknowledges
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> $stable(dn_data));

endmodule

// File: rtl/hs_proto_mon.sv
module hs_proto_mon
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic up_ack,
    input  logic dn_req,
    input  logic dn_ack,
    output logic err
);

    mon_state_e state_q, state_d;
    logic       up_req_q, dn_ack_q;
    logic       up_drop_early, dn_ack_spurious;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= MON_OK;
            up_req_q <= 1'b0;
            dn_ack_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            up_req_q <= up_req;
            dn_ack_q <= dn_ack;
        end
    end

    always_comb begin
        up_drop_early   = up_req_q && !up_req && !up_ack;
        dn_ack_spurious = !dn_ack_q && dn_ack && !dn_req;
        state_d = state_q;
        unique case (state_q)
            MON_OK:  if (up_drop_early || dn_ack_spurious) state_d = MON_ERR;
            MON_ERR: state_d = MON_ERR;
            default: state_d = MON_OK;
        endcase
    end

    always_comb begin
        err = (state_q == MON_ERR);
    end

    // R12: the error flag is sticky
    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R11: an early upstream drop is always flagged
    p_up_drop_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(up_req) && !up_ack) |=> err);

endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl
    import hs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  delay_cfg,
    input  logic              up_req,
    output logic              up_ack,
    input  logic [DATA_W-1:0] up_data,
    output logic              latch_en,
    output logic [DATA_W-1:0] fn_arg,
    output logic              start,
    input  logic [DATA_W-1:0] fn_res,
    output logic              done,
    output logic              dn_req,
    input  logic              dn_ack,
    output logic [DATA_W-1:0] dn_data,
    output logic              proto_err
);

    logic              en_w, cap_evt, start_w, unused_set;
    logic [DATA_W-1:0] lat_q;

    hs_celem u_capture (
        .clk(clk), .rst_n(rst_n),
        .in_a(up_req), .in_b(!dn_ack),
        .y(en_w), .set_evt(cap_evt)
    );

    hs_celem u_launch (
        .clk(clk), .rst_n(rst_n),
        .in_a(en_w), .in_b(!dn_ack),
        .y(start_w), .set_evt(unused_set)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lat_q <= '0;
        else if (cap_evt) lat_q <= up_data;
    end

    hs_delay_unit #(.CNT_W(CNT_W)) u_delay (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .cfg(delay_cfg), .done(done)
    );

    hs_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .done(done), .fn_res(fn_res),
        .dn_ack(dn_ack), .dn_req(dn_req), .dn_data(dn_data)
    );

    hs_proto_mon u_mon (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_ack(en_w),
        .dn_req(dn_req), .dn_ack(dn_ack),
        .err(proto_err)
    );

    always_comb begin
        latch_en = en_w;
        up_ack   = en_w;
        start    = start_w;
        fn_arg   = lat_q;
    end

    // R3: a new enable edge presents the word sampled at that edge
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_en) |-> (fn_arg == $past(up_data)));
    // R5: start rises only after enable, with the receiver idle
    p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start) |-> ($past(latch_en) && !$past(dn_ack)));
    // R10: nothing is accepted while the receiver still acknowledges
    p_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_ack |=> !$rose(latch_en));
    // R4: upstream acknowledge tracks the latch enable
    p_ack_is_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack == latch_en);

endmodule

// File: tb/tb_hs_stage_ctrl.sv
module tb_hs_stage_ctrl;

    localparam int DATA_W  = 16;
    localparam int CNT_W   = 8;
    localparam int CLK_PER = 10;
    localparam int WD_MAX  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  delay_cfg = '0;
    logic              up_req = 1'b0;
    logic              up_ack;
    logic [DATA_W-1:0] up_data = '0;
    logic              latch_en;
    logic [DATA_W-1:0] fn_arg;
    logic              start;
    logic [DATA_W-1:0] fn_res;
    logic              done;
    logic              dn_req;
    logic              dn_ack = 1'b0;
    logic [DATA_W-1:0] dn_data;
    logic              proto_err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    function automatic logic [DATA_W-1:0] stage_fn(input logic [DATA_W-1:0] x);
        return {x[7:0], x[15:8]} ^ 16'h5A3C;
    endfunction

    function automatic int eff_delay(input logic [CNT_W-1:0] c);
        return (c == 0) ? 1 : int'(c);
    endfunction

    assign fn_res = stage_fn(fn_arg);

    hs_stage_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .delay_cfg(delay_cfg),
        .up_req(up_req), .up_ack(up_ack), .up_data(up_data),
        .latch_en(latch_en), .fn_arg(fn_arg), .start(start),
        .fn_res(fn_res), .done(done), .dn_req(dn_req),
        .dn_ack(dn_ack), .dn_data(dn_data), .proto_err(proto_err)
    );

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_MAX) begin
            total++;
            bad++;
            $display("FAIL R13 watchdog expired act=%0d exp<%0d", cyc, WD_MAX);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; up_req = 1'b0; dn_ack = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // present a word with dn_ack low; returns at the negedge where up_ack is due
    task automatic accept_phase(input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] c);
        delay_cfg = c;
        up_data   = d;
        up_req    = 1'b1;
        @(negedge clk);
        chk(up_ack == 1'b1 && latch_en == 1'b1, "R3 accept after one edge", {30'd0, up_ack, latch_en}, 32'h3);
        chk(up_ack == latch_en, "R4 ack equals enable", {31'd0, up_ack}, {31'd0, latch_en});
        chk(fn_arg == d, "R3 captured word", {16'd0, fn_arg}, {16'd0, d});
        chk(start == 1'b0, "R5 start not yet", {31'd0, start}, 32'd0);
    endtask

    // from the up_ack negedge to dn_req low with dn_ack left high
    task automatic rest_phase(input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] c,
                              input int dn_lat);
        int n;
        logic [DATA_W-1:0] exp_out;
        exp_out = stage_fn(d);
        up_req = 1'b0;
        @(negedge clk);
        chk(start == 1'b1, "R5 start one edge after enable", {31'd0, start}, 32'd1);
        chk(done == 1'b0, "R6 done not at start", {31'd0, done}, 32'd0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 400);
        chk(n == eff_delay(c), "R6 matched delay length", n, eff_delay(c));
        chk(dn_req == 1'b0, "R7 no request before done", {31'd0, dn_req}, 32'd0);
        @(negedge clk);
        chk(dn_req == 1'b1, "R7 request after done", {31'd0, dn_req}, 32'd1);
        chk(dn_data == exp_out, "R7 result word", {16'd0, dn_data}, {16'd0, exp_out});
        for (int i = 0; i < dn_lat; i++) begin
            @(negedge clk);
            chk(dn_req == 1'b1 && dn_data == exp_out, "R8 offer held stable",
                {15'd0, dn_req, dn_data}, {15'd0, 1'b1, exp_out});
        end
        dn_ack = 1'b1;
        @(negedge clk);
        chk(latch_en == 1'b0 && up_ack == 1'b0, "R9 enable drops", {30'd0, latch_en, up_ack}, 32'd0);
        chk(start == 1'b1, "R9 start still high", {31'd0, start}, 32'd1);
        @(negedge clk);
        chk(start == 1'b0 && dn_req == 1'b1, "R9 start drops first", {30'd0, start, dn_req}, 32'h1);
        @(negedge clk);
        chk(dn_req == 1'b0 && done == 1'b0, "R9 request and done drop", {30'd0, dn_req, done}, 32'd0);
    endtask

    task automatic transfer(input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] c,
                            input int dn_lat, input int gap);
        accept_phase(d, c);
        rest_phase(d, c, dn_lat);
        dn_ack = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        logic [DATA_W-1:0] w;
        logic [CNT_W-1:0]  c;
        void'($urandom(32'h1C0DE5));

        do_reset();
        chk({up_ack, latch_en, start, done, dn_req, proto_err} == 6'b0,
            "R1 reset state", {26'd0, up_ack, latch_en, start, done, dn_req, proto_err}, 32'd0);

        // directed delay corners
        transfer(16'h1234, 8'd0, 0, 0);
        transfer(16'hBEEF, 8'd1, 2, 1);
        transfer(16'h00FF, 8'd255, 1, 0);
        transfer(16'hFFFF, 8'd2, 0, 2);

        // R10: request held while downstream still acknowledges
        accept_phase(16'hA001, 8'd3);
        rest_phase(16'hA001, 8'd3, 1);
        up_data = 16'hC0DE;
        up_req  = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(up_ack == 1'b0 && fn_arg == 16'hA001, "R10 blocked while dn_ack high",
                {15'd0, up_ack, fn_arg}, {16'd0, 16'hA001});
        end
        dn_ack = 1'b0;
        @(negedge clk);
        chk(up_ack == 1'b1 && fn_arg == 16'hC0DE, "R10 accepted after dn_ack low",
            {15'd0, up_ack, fn_arg}, {15'd0, 1'b1, 16'hC0DE});
        rest_phase(16'hC0DE, 8'd3, 0);
        dn_ack = 1'b0;
        @(negedge clk);

        // R13: randomized stream, in-order delivery checked per word
        for (int k = 0; k < 40; k++) begin
            w = DATA_W'($urandom);
            c = CNT_W'($urandom_range(0, 12));
            transfer(w, c, int'($urandom_range(0, 5)), int'($urandom_range(0, 3)));
        end
        chk(proto_err == 1'b0, "R13 clean stream raises no error", {31'd0, proto_err}, 32'd0);

        // R11: upstream drops request before it was acknowledged
        accept_phase(16'h5555, 8'd1);
        rest_phase(16'h5555, 8'd1, 0);
        up_req = 1'b1;
        repeat (2) @(negedge clk);
        chk(proto_err == 1'b0, "R11 no error while waiting", {31'd0, proto_err}, 32'd0);
        up_req = 1'b0;
        @(negedge clk);
        chk(proto_err == 1'b1, "R11 early upstream drop flagged", {31'd0, proto_err}, 32'd1);
        dn_ack = 1'b0;

        do_reset();
        chk(proto_err == 1'b0, "R1 reset clears error", {31'd0, proto_err}, 32'd0);

        // R12: spurious downstream acknowledge, then stickiness
        dn_ack = 1'b1;
        @(negedge clk);
        chk(proto_err == 1'b1, "R12 spurious dn_ack flagged", {31'd0, proto_err}, 32'd1);
        dn_ack = 1'b0;
        repeat (5) @(negedge clk);
        chk(proto_err == 1'b1, "R12 error stays set", {31'd0, proto_err}, 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule